// File: doc/BRIEF.md
# Oversize Frame Splitter with Signaling Header

This block sits in the encrypting direction of a layer-2 link cipher. It takes Ethernet frames that already carry a 16-byte initialisation vector directly behind the EtherType, on a 32-bit word stream with start, end and byte-empty sideband. It places a 32-bit signaling word between the EtherType and the IV. When the frame with that word added would be longer than the largest allowed Ethernet frame (1514 bytes without CRC, set by `MAX_BYTES`), it sends the frame as two frames. The second frame carries its own copy of the 14-byte MAC header and its own signaling word. The CRC is not part of the stream.

Each frame is written whole into a word RAM, and its byte length is pushed into a small length FIFO. The emitter is a state machine. `ST_IDLE` waits for a length entry and latches the length, the cipher configuration and the index. `ST_HDR` sends the three header words. `ST_SIGH` sends the EtherType with the upper signaling half. `ST_SIGL` sends the lower signaling half with the first two following bytes. `ST_BODY` copies the remaining words.

The transitions are as follows. `ST_IDLE` goes to `ST_HDR` when the FIFO is not empty. `ST_HDR` goes to `ST_SIGH` after the third word, and `ST_SIGH` always goes to `ST_SIGL`. `ST_SIGL` goes to `ST_BODY` unless it holds the fragment's last word. The last word of a fragment leads back to `ST_HDR` for the second fragment of a split frame. Otherwise it leads to `ST_IDLE`, pops the FIFO and frees the RAM words.

Top module: `oversize_frame_splitter`

## Requirements
- R1: Every output fragment consists of the 14 header bytes, the 4-byte signaling word with its most significant byte first, and then the following input bytes in order. Byte 0 of a word is on bits 31:24.
- R2: An input frame of L bytes with L+4 <= MAX_BYTES leaves as one frame of L+4 bytes, with signaling bits 0 and 1 both zero.
- R3: An input frame with L+4 > MAX_BYTES leaves as two frames. The first is exactly MAX_BYTES long, has bit 0 = 1 (split) and bit 1 = 0 (first), and carries the IV and the input bytes 14 to MAX_BYTES-5.
- R4: The second fragment follows directly. It repeats input bytes 0 to 13, has bit 0 = 1 and bit 1 = 1 (second), and carries the input bytes from MAX_BYTES-4 to the end.
- R5: Signaling bits 18:8 hold the number of bytes that follow the signaling word in that fragment.
- R6: Signaling bits 29:19 hold an 11-bit index that starts at 0 after reset. It rises by one per input frame and is shared by both fragments of a split frame.
- R7: Signaling bits 7:2 carry `cfg_cipher`, sampled when emission of the frame starts. Bits 31:30 are zero.
- R8: An output fragment asserts sop on its first word and eop on its last. `out_empty` gives the number of unused low bytes in the last word, and valid does not drop inside a fragment.
- R9: No word of a frame is sent before its last input word has been taken. Up to FIFO_DEPTH frames can wait, and they leave in arrival order.
- R10: After reset no output is valid and the index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cipher | input | 6 | Static cipher parameter bits for the signaling word |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Input word, first byte on bits 31:24 |
| in_sop | input | 1 | First word of an input frame |
| in_eop | input | 1 | Last word of an input frame |
| in_empty | input | 2 | Unused low bytes in the last input word |
| out_valid | output | 1 | Output word valid |
| out_data | output | 32 | Output word, first byte on bits 31:24 |
| out_sop | output | 1 | First word of an output fragment |
| out_eop | output | 1 | Last word of an output fragment |
| out_empty | output | 2 | Unused low bytes in the last output word |

## Verification
The assertions assume that input frames are well framed, with sop and eop on the right words. They also assume that every frame is 30 to 1530 bytes long, so it holds at least the header and the IV and needs at most two fragments. Finally, they assume that the pending frames never exceed the length FIFO or the RAM. The stimulus keeps to these limits in two ways. In most cases it sends one frame and waits until the frame's fragments have left. In one burst of three frames, the combined words stay below the RAM depth while the first frame drains.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
    localparam int LEN_W     = 11;
    localparam int HDR_BYTES = 14;
    localparam int SIG_BYTES = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_SIGH,
        ST_SIGL,
        ST_BODY
    } emit_state_t;

    function automatic logic [31:0] sig_word(
        input logic             split,
        input logic             second,
        input logic [5:0]       cfg,
        input logic [LEN_W-1:0] size,
        input logic [LEN_W-1:0] idx
    );
        return {2'b00, idx, size, cfg, second, split};
    endfunction
endpackage

// File: rtl/ofs_len_fifo.sv
module ofs_len_fifo #(
    parameter int W     = 11,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_val,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0] slots [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [PW:0]   cnt;

    assign empty = (cnt == '0);
    assign full  = (cnt == (PW+1)'(DEPTH));
    assign head  = slots[rp];

    always_ff @(posedge clk) begin
        if (push) slots[wp] <= push_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + 1'b1;
            if (pop)  rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + 1'b1;
            cnt <= cnt + (PW+1)'(push) - (PW+1)'(pop);
        end
    end

    // R9: more pending frames than slots would lose a length
    assert_len_fifo_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (!full || pop));
    // R9: the emitter only finishes a frame that was queued
    assert_len_fifo_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/ofs_frame_store.sv
module ofs_frame_store import ofs_pkg::*; #(
    parameter int AW = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [31:0]      in_data,
    input  logic             in_sop,
    input  logic             in_eop,
    input  logic [1:0]       in_empty,
    input  logic [AW-1:0]    rd_addr,
    output logic [31:0]      rd_data,
    output logic             len_push,
    output logic [LEN_W-1:0] len_val
);
    localparam int DEPTH = 1 << AW;

    logic [31:0]      mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [LEN_W-1:0] wcnt, wcnt_n;
    logic [LEN_W+1:0] byte_len;

    assign wcnt_n   = in_sop ? LEN_W'(1) : wcnt + 1'b1;
    assign byte_len = {wcnt_n, 2'b00} - (LEN_W+2)'(in_empty);
    assign rd_data  = mem[rd_addr];

    always_ff @(posedge clk) begin
        if (in_valid) mem[wr_ptr] <= in_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            wcnt     <= '0;
            len_push <= 1'b0;
            len_val  <= '0;
        end else begin
            len_push <= in_valid && in_eop;
            if (in_valid) begin
                wr_ptr <= wr_ptr + 1'b1;
                wcnt   <= wcnt_n;
                if (in_eop) len_val <= byte_len[LEN_W-1:0];
            end
        end
    end

    // R9: a length is queued only right after a closing input word
    assert_len_after_eop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        len_push |-> $past(in_valid && in_eop));
endmodule

// File: rtl/ofs_emit_fsm.sv
module ofs_emit_fsm import ofs_pkg::*; #(
    parameter int AW        = 10,
    parameter int MAX_BYTES = 1514
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             len_empty,
    input  logic [LEN_W-1:0] len_head,
    output logic             len_pop,
    input  logic [5:0]       cfg,
    output logic [AW-1:0]    rd_addr,
    input  logic [31:0]      rd_data,
    output logic             out_valid,
    output logic [31:0]      out_data,
    output logic             out_sop,
    output logic             out_eop,
    output logic [1:0]       out_empty
);
    // MAX_BYTES - 4 must be 2 mod 4 so the second fragment stays word aligned
    localparam int SPLIT_OFF  = MAX_BYTES - SIG_BYTES;
    localparam int SPLIT_WORD = SPLIT_OFF / 4;
    localparam int MAX_WORDS  = (MAX_BYTES + 3) / 4;
    localparam int XW         = LEN_W + 2;

    emit_state_t      state, nxt;
    logic [AW-1:0]    base;
    logic [LEN_W-1:0] owc, src, flen, fidx;
    logic [5:0]       fcfg;
    logic             second;

    logic             split_now, last, frag_done, frame_done;
    logic [XW-1:0]    n_bytes, n_words, pad;
    logic [LEN_W-1:0] size, s_word, rd_idx;
    logic [31:0]      sig;

    always_comb begin
        split_now = (XW'(flen) + XW'(SIG_BYTES)) > XW'(MAX_BYTES);
        if (second) begin
            n_bytes = XW'(flen) - XW'(SPLIT_OFF - HDR_BYTES - SIG_BYTES);
            size    = flen - LEN_W'(SPLIT_OFF);
            s_word  = LEN_W'(SPLIT_WORD);
        end else if (split_now) begin
            n_bytes = XW'(MAX_BYTES);
            size    = LEN_W'(SPLIT_OFF - HDR_BYTES);
            s_word  = LEN_W'(HDR_BYTES / 4);
        end else begin
            n_bytes = XW'(flen) + XW'(SIG_BYTES);
            size    = flen - LEN_W'(HDR_BYTES);
            s_word  = LEN_W'(HDR_BYTES / 4);
        end
        n_words    = (n_bytes + XW'(3)) >> 2;
        pad        = (n_words << 2) - n_bytes;
        last       = (XW'(owc) == (n_words - XW'(1)));
        frag_done  = ((state == ST_SIGL) || (state == ST_BODY)) && last;
        frame_done = frag_done && !(split_now && !second);
        sig        = sig_word(split_now, second, fcfg, size, fidx);
    end

    always_comb begin
        unique case (state)
            ST_HDR:  rd_idx = owc;
            ST_SIGH: rd_idx = LEN_W'(HDR_BYTES / 4);
            ST_SIGL: rd_idx = s_word;
            ST_BODY: rd_idx = src;
            default: rd_idx = '0;
        endcase
        rd_addr = base + AW'(rd_idx);
        len_pop = frame_done;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (!len_empty) nxt = ST_HDR;
            ST_HDR:  if (owc == LEN_W'(2)) nxt = ST_SIGH;
            ST_SIGH: nxt = ST_SIGL;
            ST_SIGL: nxt = frag_done ? (frame_done ? ST_IDLE : ST_HDR) : ST_BODY;
            ST_BODY: if (frag_done) nxt = frame_done ? ST_IDLE : ST_HDR;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            base   <= '0;
            owc    <= '0;
            src    <= '0;
            flen   <= '0;
            fidx   <= '0;
            fcfg   <= '0;
            second <= 1'b0;
        end else begin
            state <= nxt;
            unique case (state)
                ST_IDLE: if (!len_empty) begin
                    flen   <= len_head;
                    fcfg   <= cfg;
                    second <= 1'b0;
                    owc    <= '0;
                end
                ST_HDR, ST_SIGH: owc <= owc + 1'b1;
                ST_SIGL: begin
                    owc <= owc + 1'b1;
                    src <= s_word + 1'b1;
                end
                ST_BODY: begin
                    owc <= owc + 1'b1;
                    src <= src + 1'b1;
                end
                default: ;
            endcase
            if (frag_done) begin
                owc <= '0;
                if (frame_done) begin
                    base <= base + AW'((XW'(flen) + XW'(3)) >> 2);
                    fidx <= fidx + 1'b1;
                end else begin
                    second <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        out_valid = (state != ST_IDLE);
        out_sop   = (state == ST_HDR) && (owc == '0);
        out_eop   = frag_done;
        out_empty = frag_done ? pad[1:0] : 2'b00;
        unique case (state)
            ST_HDR:  out_data = rd_data;
            ST_SIGH: out_data = {rd_data[31:16], sig[31:16]};
            ST_SIGL: out_data = {sig[15:0], rd_data[15:0]};
            ST_BODY: out_data = rd_data;
            default: out_data = '0;
        endcase
    end

    // R8: a fragment opens with sop
    assert_sop_opens_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> out_sop);
    // R8: no gap and no new start inside a fragment
    assert_frag_contiguous_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_eop) |=> (out_valid && !out_sop));
    // R4: the second fragment follows the first one without a gap
    assert_second_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_eop && split_now && !second) |=> (out_valid && out_sop && second));
    // R3: no fragment grows past the maximum frame length
    assert_frag_within_max_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(owc) < MAX_WORDS));
endmodule

// File: rtl/oversize_frame_splitter.sv
module oversize_frame_splitter import ofs_pkg::*; #(
    parameter int AW         = 10,
    parameter int FIFO_DEPTH = 4,
    parameter int MAX_BYTES  = 1514
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [5:0]  cfg_cipher,
    input  logic        in_valid,
    input  logic [31:0] in_data,
    input  logic        in_sop,
    input  logic        in_eop,
    input  logic [1:0]  in_empty,
    output logic        out_valid,
    output logic [31:0] out_data,
    output logic        out_sop,
    output logic        out_eop,
    output logic [1:0]  out_empty
);
    logic [AW-1:0]    rd_addr;
    logic [31:0]      rd_data;
    logic             len_push, len_pop, len_empty, len_full;
    logic [LEN_W-1:0] len_val, len_head;

    ofs_frame_store #(.AW(AW)) u_store (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_sop(in_sop),
        .in_eop(in_eop), .in_empty(in_empty),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .len_push(len_push), .len_val(len_val)
    );

    ofs_len_fifo #(.W(LEN_W), .DEPTH(FIFO_DEPTH)) u_lens (
        .clk(clk), .rst_n(rst_n),
        .push(len_push), .push_val(len_val), .pop(len_pop),
        .head(len_head), .empty(len_empty), .full(len_full)
    );

    ofs_emit_fsm #(.AW(AW), .MAX_BYTES(MAX_BYTES)) u_emit (
        .clk(clk), .rst_n(rst_n),
        .len_empty(len_empty), .len_head(len_head), .len_pop(len_pop),
        .cfg(cfg_cipher), .rd_addr(rd_addr), .rd_data(rd_data),
        .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop),
        .out_eop(out_eop), .out_empty(out_empty)
    );
endmodule

// File: tb/sim_oversize_frame_splitter.sv
module sim_oversize_frame_splitter;
    localparam int CLK_PERIOD = 10;
    localparam int MAXB = 1514;
    localparam int NT = 8;
    localparam int T_LEN [NT] = '{30, 64, 301, 1510, 1511, 1513, 1530, 1002};
    localparam logic [5:0] T_CFG [NT] = '{6'h00, 6'h3F, 6'h15, 6'h2A, 6'h01, 6'h20, 6'h33, 6'h0C};
    localparam int T_NFR [NT] = '{1, 1, 1, 1, 2, 2, 2, 1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [5:0] cfg_cipher = '0;
    logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [31:0] in_data = '0;
    logic [1:0] in_empty = '0;
    logic out_valid, out_sop, out_eop;
    logic [31:0] out_data;
    logic [1:0] out_empty;

    int checks = 0, failures = 0;
    logic [7:0] cb [0:32767];
    int fe [0:63];
    int ncb = 0, nfr = 0, fr_ptr = 0, sop_err = 0, early = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    oversize_frame_splitter u0 (
        .clk(clk), .rst_n(rst_n), .cfg_cipher(cfg_cipher),
        .in_valid(in_valid), .in_data(in_data), .in_sop(in_sop),
        .in_eop(in_eop), .in_empty(in_empty),
        .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop),
        .out_eop(out_eop), .out_empty(out_empty)
    );

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (out_sop && ncb != ((nfr == 0) ? 0 : fe[nfr-1])) sop_err++;
            for (int b = 0; b < (out_eop ? 4 - int'(out_empty) : 4); b++) begin
                cb[ncb] = out_data[31-8*b -: 8];
                ncb++;
            end
            if (out_eop) begin
                fe[nfr] = ncb;
                nfr++;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] in_byte(input int f, input int i);
        return 8'((i * 7 + f * 53 + (i >> 5)) & 255);
    endfunction

    task automatic send_frame(input int f, input int len, input bit watch);
        int nw = (len + 3) / 4;
        for (int w = 0; w < nw; w++) begin
            @(negedge clk);
            if (watch && out_valid) early++;
            in_valid = 1'b1;
            in_sop   = (w == 0);
            in_eop   = (w == nw - 1);
            in_empty = (w == nw - 1) ? 2'(4 * nw - len) : 2'd0;
            for (int b = 0; b < 4; b++)
                in_data[31-8*b -: 8] = (4*w + b < len) ? in_byte(f, 4*w + b) : 8'h00;
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sop = 1'b0;
        in_eop = 1'b0;
    endtask

    task automatic wait_frags(input int n);
        while (nfr < n) @(negedge clk);
    endtask

    task automatic check_frame(input int f, input int len, input logic [5:0] cfg, input int idx);
        bit split = (len + 4 > MAXB);
        int nf = split ? 2 : 1;
        wait_frags(fr_ptr + nf);
        for (int s = 0; s < nf; s++) begin
            int start = (fr_ptr == 0) ? 0 : fe[fr_ptr-1];
            int alen = fe[fr_ptr] - start;
            int elen = (s == 1) ? len - (MAXB - 4) + 18 : (split ? MAXB : len + 4);
            int esize = elen - 18;
            int mism = 0;
            logic [31:0] sw;
            sw = {cb[start+14], cb[start+15], cb[start+16], cb[start+17]};
            check(alen == elen, split ? (s == 1 ? "R4 length" : "R3 length") : "R2 length", alen, elen);
            check(sw[0] == split, "R2/R3 split bit", int'(sw[0]), int'(split));
            check(sw[1] == (s == 1), "R4 order bit", int'(sw[1]), s);
            check(int'(sw[18:8]) == esize, "R5 size field", int'(sw[18:8]), esize);
            check(int'(sw[29:19]) == idx, "R6 index field", int'(sw[29:19]), idx);
            check(sw[7:2] == cfg && sw[31:30] == 2'b00, "R7 cfg and top bits",
                  int'(sw[31:30]) * 64 + int'(sw[7:2]), int'(cfg));
            for (int p = 0; p < ((alen < elen) ? alen : elen); p++) begin
                int srci;
                if (p < 14) srci = p;
                else if (p < 18) continue;
                else srci = (s == 1) ? (MAXB - 4) + (p - 18) : 14 + (p - 18);
                if (cb[start+p] != in_byte(f, srci)) mism++;
            end
            check(mism == 0, (s == 1) ? "R4 header and data bytes" : "R1 header and data bytes", mism, 0);
            fr_ptr++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", nfr, fr_ptr);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R10 idle after reset", int'(out_valid), 0);

        for (int k = 0; k < NT; k++) begin
            cfg_cipher = T_CFG[k];
            early = 0;
            send_frame(k, T_LEN[k], 1'b1);
            check(early == 0, "R9 no output before frame end", early, 0);
            check(((T_LEN[k] + 4 > MAXB) ? 2 : 1) == T_NFR[k], "R3 fragment count table", T_NFR[k], T_NFR[k]);
            check_frame(k, T_LEN[k], T_CFG[k], k);
            check(nfr == fr_ptr, "R2/R3 no extra fragments", nfr, fr_ptr);
        end

        // Burst of three frames sent without waiting; order must hold (R9)
        cfg_cipher = 6'h2D;
        send_frame(20, 1530, 1'b0);
        send_frame(21, 45, 1'b0);
        send_frame(22, 1512, 1'b0);
        check_frame(20, 1530, 6'h2D, 8);
        check_frame(21, 45, 6'h2D, 9);
        check_frame(22, 1512, 6'h2D, 10);
        check(sop_err == 0, "R8 sop on first word", sop_err, 0);

        // Reset again: index restarts at zero (R10)
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R10 idle after second reset", int'(out_valid), 0);
        cfg_cipher = 6'h11;
        send_frame(30, 100, 1'b1);
        check_frame(30, 100, 6'h11, 0);
        repeat (20) @(negedge clk);
        check(nfr == fr_ptr, "R9 nothing left queued", nfr, fr_ptr);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule